// File: doc/BRIEF.md
# Float/Integer Register Bit Move Unit

This unit carries a value between the floating-point register domain and the integer register domain as a raw bit copy, with no trip through memory and no arithmetic. A direction input picks float-to-integer or integer-to-float. A 2-bit mode picks double or single width and whether a condition field is written. In double width all 64 bits pass through unchanged. In single width the unit does what a single-precision store or load does. Float-to-integer narrows the 64-bit register image to the 32-bit IEEE layout and zero-fills the upper half. Integer-to-float takes the low 32 bits of the integer word and widens them to the 64-bit register image.

One strobe on `in_valid` gives one registered result on the next clock edge. A 4-bit condition field comes with the result when the mode asks for one. If the destination is an integer register, the field is the signed compare of the result against zero plus a copied summary-overflow bit. If the destination is a floating-point register, a separate write enable marks the field, and the field carries the floating-point status bits supplied at the input. The unit changes no floating-point status, so it has no status output.

Top module: `fpgp_move`

## Requirements
- R1: `mode[1]` selects single width (1) or double width (0), and `mode[0]` enables the condition-field write. Mode values 0 and 1 are double, and 2 and 3 are single.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_word` and the condition outputs change only on such a cycle and hold their values otherwise.
- R3: In double width, `out_word` equals `src_word` bit for bit in both directions (`to_float` = 0 is float-to-integer, 1 is integer-to-float).
- R4: Single-width float-to-integer gives `out_word[63:32]` = 0. If the source exponent field (bits 62:52) is outside 874..896, `out_word[31:0]` = {src[63], src[62], src[58:29]}. This covers zeros, normals, infinities and NaNs.
- R5: Single-width float-to-integer with a source exponent field in 874..896 gives a denormal single {src[63], 8'h00, F}. F is the low 23 bits of {1, src[51:0]} shifted right by (926 − exponent). Discarded bits are truncated and never rounded.
- R6: Single-width integer-to-float uses only `src_word[31:0]`. A single exponent of 255 maps to 2047, an exponent of 1..254 maps to exponent+896, and a zero of either sign stays a zero. In these cases the 23-bit fraction is placed in the top of the 52-bit fraction, and the sign is kept.
- R7: Single-width integer-to-float with a denormal single (exponent 0, fraction ≠ 0) normalises it. Let p be the position of the fraction's leading one. The double exponent is 874+p, and the fraction bits below that one are left-aligned in the 52-bit fraction.
- R8: With `mode[0]` = 1 and `to_float` = 0, `int_cc_we` is 1 and `cc_field` = {lt, gt, eq, so}. Here lt, gt and eq come from a signed 64-bit compare of `out_word` with zero, and so is a copy of `sum_ovf`.
- R9: With `mode[0]` = 1 and `to_float` = 1, `fp_cc_we` is 1 and `cc_field` equals `fp_status`. `int_cc_we` and `fp_cc_we` are never high together.
- R10: With `mode[0]` = 0, neither write enable is high and `cc_field` is 0.
- R11: After reset, `out_valid`, `out_word`, both write enables and `cc_field` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: one move request |
| to_float | input | 1 | 0 = float to integer, 1 = integer to float |
| mode | input | 2 | [1] single width, [0] condition write enable |
| src_word | input | 64 | Source register value |
| sum_ovf | input | 1 | Summary-overflow bit copied into the integer condition field |
| fp_status | input | 4 | Floating-point status bits copied into the float condition field |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_word | output | 64 | Destination register value |
| int_cc_we | output | 1 | Integer condition field write |
| fp_cc_we | output | 1 | Floating-point condition field write |
| cc_field | output | 4 | Condition field value |

## Verification
In one cycle the result word and the condition field are both produced, and the condition field must come from the same result it travels with. Sign effects are the main risk. A negative single narrowed into a zero-filled word must report greater-than, not less-than. A negative double must report less-than. Both cases are checked. The bench also sends back-to-back strobes that change direction from one cycle to the next. Each cycle is then judged on its own: the word, which write enable is high, and the field contents must all belong to that cycle's request and not to its neighbour's.

// File: rtl/fpgp_move.sv
module fpgp_move (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        to_float,
  input  logic [1:0]  mode,
  input  logic [63:0] src_word,
  input  logic        sum_ovf,
  input  logic [3:0]  fp_status,
  output logic        out_valid,
  output logic [63:0] out_word,
  output logic        int_cc_we,
  output logic        fp_cc_we,
  output logic [3:0]  cc_field
);

  localparam logic [10:0] DN_LO = 11'd874;
  localparam logic [10:0] DN_HI = 11'd896;

  function automatic logic [31:0] narrow(input logic [63:0] d);
    logic [10:0] e;
    logic [52:0] m;
    logic [52:0] sh;
    logic [10:0] n;
    e = d[62:52];
    m = {1'b1, d[51:0]};
    n = 11'd926 - e;
    sh = m >> n;
    if (e >= DN_LO && e <= DN_HI) narrow = {d[63], 8'h00, sh[22:0]};
    else                          narrow = {d[63:62], d[58:29]};
  endfunction

  function automatic logic [63:0] widen(input logic [31:0] s);
    logic [7:0]  e;
    logic [22:0] f;
    logic [4:0]  p;
    logic [5:0]  amt;
    logic [52:0] sh;
    e = s[30:23];
    f = s[22:0];
    p = 5'd0;
    for (int i = 0; i < 23; i++) if (f[i]) p = 5'(i);
    amt = 6'd52 - {1'b0, p};
    sh = {30'b0, f} << amt;
    if (e == 8'hFF)       widen = {s[31], 11'h7FF, f, 29'b0};
    else if (e != 8'h00)  widen = {s[31], {3'b0, e} + DN_HI, f, 29'b0};
    else if (f == 23'b0)  widen = {s[31], 63'b0};
    else                  widen = {s[31], DN_LO + {6'b0, p}, sh[51:0]};
  endfunction

  logic [63:0] nxt_word;
  logic        nxt_iwe, nxt_fwe;
  logic [3:0]  nxt_cc;

  always_comb begin
    if (!mode[1])      nxt_word = src_word;
    else if (to_float) nxt_word = widen(src_word[31:0]);
    else               nxt_word = {32'b0, narrow(src_word)};
  end

  assign nxt_iwe = mode[0] & ~to_float;
  assign nxt_fwe = mode[0] & to_float;

  always_comb begin
    nxt_cc = 4'b0;
    if (nxt_iwe)
      nxt_cc = {nxt_word[63], ~nxt_word[63] & (|nxt_word), ~(|nxt_word), sum_ovf};
    else if (nxt_fwe)
      nxt_cc = fp_status;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      int_cc_we <= 1'b0;
      fp_cc_we  <= 1'b0;
      cc_field  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= nxt_word;
        int_cc_we <= nxt_iwe;
        fp_cc_we  <= nxt_fwe;
        cc_field  <= nxt_cc;
      end else begin
        int_cc_we <= 1'b0;
        fp_cc_we  <= 1'b0;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_word) && $stable(cc_field));
  p_double_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode[1]) |=> out_word == $past(src_word));
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1] && !to_float) |=> out_word[63:32] == 32'b0);
  p_int_cc_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int_cc_we |-> $onehot(cc_field[3:1]));
  p_cc_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_cc_we && fp_cc_we));
  p_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode[0]) |=> !int_cc_we && !fp_cc_we && cc_field == 4'b0);

endmodule

// File: tb/fpgp_move_test.sv
module fpgp_move_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        to_float = 1'b0;
  logic [1:0]  mode = 2'b0;
  logic [63:0] src_word = '0;
  logic        sum_ovf = 1'b0;
  logic [3:0]  fp_status = 4'b0;
  logic        out_valid, int_cc_we, fp_cc_we;
  logic [63:0] out_word;
  logic [3:0]  cc_field;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  fpgp_move uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .to_float(to_float),
    .mode(mode), .src_word(src_word), .sum_ovf(sum_ovf), .fp_status(fp_status),
    .out_valid(out_valid), .out_word(out_word), .int_cc_we(int_cc_we),
    .fp_cc_we(fp_cc_we), .cc_field(cc_field)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic tf, input logic [1:0] md, input logic [63:0] s,
                       input logic so, input logic [3:0] fs);
    to_float = tf; mode = md; src_word = s; sum_ovf = so; fp_status = fs; in_valid = 1'b1;
  endtask

  task automatic expect_out(input string tag, input logic [63:0] w, input logic iwe,
                            input logic fwe, input logic [3:0] cc);
    chk({tag, " valid R2"}, {63'b0, out_valid}, 64'd1);
    chk({tag, " word"}, out_word, w);
    chk({tag, " int_we"}, {63'b0, int_cc_we}, {63'b0, iwe});
    chk({tag, " fp_we"}, {63'b0, fp_cc_we}, {63'b0, fwe});
    chk({tag, " cc"}, {60'b0, cc_field}, {60'b0, cc});
  endtask

  task automatic one_move(input string tag, input logic tf, input logic [1:0] md,
                          input logic [63:0] s, input logic so, input logic [3:0] fs,
                          input logic [63:0] w, input logic iwe, input logic fwe,
                          input logic [3:0] cc);
    @(negedge clk); drive(tf, md, s, so, fs);
    @(negedge clk); in_valid = 1'b0; expect_out(tag, w, iwe, fwe, cc);
  endtask

  task automatic t_reset;
    chk("R11 valid", {63'b0, out_valid}, 64'd0);
    chk("R11 word", out_word, 64'd0);
    chk("R11 we", {62'b0, int_cc_we, fp_cc_we}, 64'd0);
    chk("R11 cc", {60'b0, cc_field}, 64'd0);
  endtask

  task automatic t_double;
    one_move("R3 f2i neg R8 lt", 1'b0, 2'd1, 64'hC000_0000_0000_0000, 1'b1, 4'h0,
             64'hC000_0000_0000_0000, 1'b1, 1'b0, 4'b1001);
    one_move("R3 i2f R10", 1'b1, 2'd0, 64'h0123_4567_89AB_CDEF, 1'b1, 4'hF,
             64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 4'b0000);
    one_move("R1 R3 f2i no flag R10", 1'b0, 2'd0, 64'h8000_0000_0000_0001, 1'b1, 4'h0,
             64'h8000_0000_0000_0001, 1'b0, 1'b0, 4'b0000);
  endtask

  task automatic t_narrow;
    one_move("R4 one", 1'b0, 2'd2, 64'h3FF0_0000_0000_0000, 1'b0, 4'h0,
             64'h0000_0000_3F80_0000, 1'b0, 1'b0, 4'b0000);
    one_move("R4 neg R8 gt", 1'b0, 2'd3, 64'hC004_0000_0000_0000, 1'b0, 4'h0,
             64'h0000_0000_C020_0000, 1'b1, 1'b0, 4'b0100);
    one_move("R4 inf", 1'b0, 2'd2, 64'h7FF0_0000_0000_0000, 1'b0, 4'h0,
             64'h0000_0000_7F80_0000, 1'b0, 1'b0, 4'b0000);
    one_move("R4 nan", 1'b0, 2'd2, 64'h7FF8_0000_0000_0000, 1'b0, 4'h0,
             64'h0000_0000_7FC0_0000, 1'b0, 1'b0, 4'b0000);
    one_move("R4 zero R8 eq", 1'b0, 2'd3, 64'h0, 1'b0, 4'h0,
             64'h0, 1'b1, 1'b0, 4'b0010);
    one_move("R5 top denorm", 1'b0, 2'd2, 64'h3800_0000_0000_0000, 1'b0, 4'h0,
             64'h0000_0000_0040_0000, 1'b0, 1'b0, 4'b0000);
    one_move("R5 low denorm", 1'b0, 2'd2, 64'h36A0_0000_0000_0000, 1'b0, 4'h0,
             64'h0000_0000_0000_0001, 1'b0, 1'b0, 4'b0000);
    one_move("R5 truncate", 1'b0, 2'd2, 64'h3800_0000_3FFF_FFFF, 1'b0, 4'h0,
             64'h0000_0000_0040_0000, 1'b0, 1'b0, 4'b0000);
  endtask

  task automatic t_widen;
    one_move("R6 one upper ignored", 1'b1, 2'd2, 64'hDEAD_BEEF_3F80_0000, 1'b0, 4'h0,
             64'h3FF0_0000_0000_0000, 1'b0, 1'b0, 4'b0000);
    one_move("R6 neg inf", 1'b1, 2'd2, 64'h0000_0000_FF80_0000, 1'b0, 4'h0,
             64'hFFF0_0000_0000_0000, 1'b0, 1'b0, 4'b0000);
    one_move("R6 nan R9", 1'b1, 2'd3, 64'h0000_0000_7FC0_0001, 1'b1, 4'b1010,
             64'h7FF8_0000_2000_0000, 1'b0, 1'b1, 4'b1010);
    one_move("R6 neg zero", 1'b1, 2'd2, 64'h0000_0000_8000_0000, 1'b0, 4'h0,
             64'h8000_0000_0000_0000, 1'b0, 1'b0, 4'b0000);
    one_move("R7 min denorm", 1'b1, 2'd2, 64'h0000_0000_0000_0001, 1'b0, 4'h0,
             64'h36A0_0000_0000_0000, 1'b0, 1'b0, 4'b0000);
    one_move("R7 max bit denorm", 1'b1, 2'd2, 64'h0000_0000_0040_0000, 1'b0, 4'h0,
             64'h3800_0000_0000_0000, 1'b0, 1'b0, 4'b0000);
    one_move("R7 two bit denorm", 1'b1, 2'd2, 64'h0000_0000_0000_0003, 1'b0, 4'h0,
             64'h36B8_0000_0000_0000, 1'b0, 1'b0, 4'b0000);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); drive(1'b0, 2'd1, 64'h0000_0000_0000_0005, 1'b0, 4'h0);
    @(negedge clk);
    expect_out("R8 b2b first", 64'h5, 1'b1, 1'b0, 4'b0100);
    drive(1'b1, 2'd3, 64'h0000_0000_3F80_0000, 1'b1, 4'b0110);
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R9 b2b second", 64'h3FF0_0000_0000_0000, 1'b0, 1'b1, 4'b0110);
  endtask

  task automatic t_hold;
    one_move("R2 setup", 1'b0, 2'd0, 64'h1111_2222_3333_4444, 1'b0, 4'h0,
             64'h1111_2222_3333_4444, 1'b0, 1'b0, 4'b0000);
    to_float = 1'b1; mode = 2'd3; src_word = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    chk("R2 idle valid", {63'b0, out_valid}, 64'd0);
    chk("R2 idle word", out_word, 64'h1111_2222_3333_4444);
    chk("R2 idle we", {62'b0, int_cc_we, fp_cc_we}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_double;
    t_narrow;
    t_widen;
    t_back_to_back;
    t_hold;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule